// File: doc/BRIEF.md
# Idle-Checked Serial Bus Transmitter with Echo Collision Detect

This block sends one byte at a time as an asynchronous frame onto a shared wired-AND bus, where any station can pull the line low. After a byte is handed over, the block looks at the synchronized line twice in a row. If both looks find the line high, it drives the start bit on the very next clock. If either look finds the line low, it drops the byte, pulses an abort flag and waits to be given a byte again. The bit-period counter is cleared at the launch, so every bit boundary is measured from the start-bit edge. No earlier free-running divider phase affects it.

While the frame is on the wire, an echo receiver samples the line in the middle of each data bit. At the end of the eighth data bit, the echoed byte is compared with the sent byte. On a mismatch, the stop bit is skipped, the line is released high and a one-cycle collision flag is raised. Otherwise the stop level is sent for one full bit and a one-cycle done flag marks the end of the frame. The bit length is a parameter counted in clock cycles, for example 600 clocks at 10 MHz for a 60 us bit.

Top module: `echo_bus_tx`

## Requirements
- R1: After reset, `bus_out` is high, `in_ready` is high, and `sent_p`, `clash_p` and `abort_p` are low.
- R2: A byte is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the cycle in which `sent_p`, `clash_p` or `abort_p` is high.
- R3: After a byte is taken, the block requires two consecutive high synchronized samples of `bus_in`. With the line steadily high, `bus_out` goes low 2 cycles after the accept edge, which is one cycle after the second idle sample.
- R4: If a synchronized sample during the idle check is low, `abort_p` is high for one cycle, 1 cycle after the accept edge. `in_ready` returns high in that same cycle, `bus_out` is never driven low, and all transmit state is cleared.
- R5: The frame is a low start bit, then 8 data bits with bit 0 first, then a high stop bit. Each bit lasts exactly `BIT_CLKS` cycles, counted from the start-bit edge.
- R6: Without a collision, `sent_p` is high for exactly one cycle, `10*BIT_CLKS` cycles after the start-bit edge. `in_ready` is high in that same cycle.
- R7: The echo takes `bus_in` at the middle of each data bit, bit 0 first. If the echoed byte differs from the sent byte, `clash_p` is high for one cycle, `9*BIT_CLKS` cycles after the start-bit edge. In that cycle `bus_out` is high and `in_ready` is high, no stop bit is sent, and no `sent_p` follows.
- R8: Another station pulling the line low during a bit this block sends as 0 does not change the echo, so no collision is reported.
- R9: `in_valid` and `in_data` have no effect while a frame is in progress. The bits on `bus_out` follow the byte that was taken, and no new frame starts unless `in_valid` is raised again while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| bus_out | output | 1 | Line drive, 0 pulls the bus low |
| bus_in | input | 1 | Line as seen on the bus (asynchronous) |
| sent_p | output | 1 | One-cycle pulse, frame sent without collision |
| clash_p | output | 1 | One-cycle pulse, echo mismatch |
| abort_p | output | 1 | One-cycle pulse, bus found busy at the idle check |

## Verification
Every result is counted from the clock edge that takes a byte. The abort pulse is due 1 cycle later and the start-bit edge 2 cycles later. Each bit level must hold from `k*BIT_CLKS` through `k*BIT_CLKS+BIT_CLKS-1` cycles after that edge. The collision pulse is due at `9*BIT_CLKS` and the done pulse at `10*BIT_CLKS`. The bench keeps a free-running edge counter and waits on exact target counts. It reads outputs on the falling clock edge, so the registered result of edge N is checked while the counter holds N. Interference from another station is injected only well inside a bit, clear of the two-flop synchronizer delay on either side of the mid-bit sample.

// File: rtl/ebtx_pkg.sv
package ebtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SEND  = 2'd2
  } tx_state_t;

  localparam int unsigned DATA_BITS = 8;
  // bit slot index: 0 start, 1..DATA_BITS data, DATA_BITS+1 stop
  localparam int unsigned SLOT_W = $clog2(DATA_BITS + 2);
endpackage

// File: rtl/ebtx_sync2.sv
module ebtx_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic meta_q, stab_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end
  assign dout = stab_q;
endmodule

// File: rtl/ebtx_bit_timer.sv
module ebtx_bit_timer #(
  parameter int unsigned BIT_CLKS = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic bit_end,
  output logic mid_pt
);
  localparam int unsigned CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] MID  = CW'(BIT_CLKS / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end = run && (cnt_q == LAST);
  assign mid_pt  = run && (cnt_q == MID);
endmodule

// File: rtl/ebtx_echo_rx.sv
module ebtx_echo_rx #(
  parameter int unsigned DBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic             line,
  output logic [DBITS-1:0] echo
);
  logic [DBITS-1:0] sh_q;
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q <= '0;
    end else if (take) begin
      sh_q <= {line, sh_q[DBITS-1:1]};
    end
  end
  assign echo = sh_q;
endmodule

// File: rtl/echo_bus_tx.sv
module echo_bus_tx
  import ebtx_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       bus_out,
  input  logic       bus_in,
  output logic       sent_p,
  output logic       clash_p,
  output logic       abort_p
);
  localparam logic [SLOT_W-1:0] LAST_DATA = SLOT_W'(DATA_BITS);
  localparam logic [SLOT_W-1:0] STOP_SLOT = SLOT_W'(DATA_BITS + 1);

  tx_state_t            state_q;
  logic [DATA_BITS-1:0] byte_q;
  logic [SLOT_W-1:0]    slot_q;
  logic                 seen_q;
  logic                 bus_s;
  logic                 launch, bit_end, mid_pt, take;
  logic [DATA_BITS-1:0] echo;

  ebtx_sync2 u_sync (
    .clk (clk), .rst (rst), .din (bus_in), .dout (bus_s)
  );

  assign launch = (state_q == ST_CHECK) && bus_s && seen_q;

  ebtx_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk (clk), .rst (rst), .restart (launch),
    .run (state_q == ST_SEND), .bit_end (bit_end), .mid_pt (mid_pt)
  );

  assign take = mid_pt && (slot_q != '0) && (slot_q <= LAST_DATA);

  ebtx_echo_rx #(.DBITS(DATA_BITS)) u_echo (
    .clk (clk), .rst (rst), .clear (launch), .take (take),
    .line (bus_s), .echo (echo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      byte_q   <= '0;
      slot_q   <= '0;
      seen_q   <= 1'b0;
      in_ready <= 1'b1;
      bus_out  <= 1'b1;
      sent_p   <= 1'b0;
      clash_p  <= 1'b0;
      abort_p  <= 1'b0;
    end else begin
      sent_p  <= 1'b0;
      clash_p <= 1'b0;
      abort_p <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid && in_ready) begin
            byte_q   <= in_data;
            seen_q   <= 1'b0;
            in_ready <= 1'b0;
            state_q  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!bus_s) begin
            abort_p  <= 1'b1;
            in_ready <= 1'b1;
            byte_q   <= '0;
            seen_q   <= 1'b0;
            state_q  <= ST_IDLE;
          end else if (seen_q) begin
            bus_out <= 1'b0;
            slot_q  <= '0;
            state_q <= ST_SEND;
          end else begin
            seen_q <= 1'b1;
          end
        end
        ST_SEND: begin
          if (bit_end) begin
            if (slot_q == LAST_DATA) begin
              bus_out <= 1'b1;
              if (echo != byte_q) begin
                clash_p  <= 1'b1;
                in_ready <= 1'b1;
                slot_q   <= '0;
                state_q  <= ST_IDLE;
              end else begin
                slot_q <= STOP_SLOT;
              end
            end else if (slot_q == STOP_SLOT) begin
              sent_p   <= 1'b1;
              in_ready <= 1'b1;
              slot_q   <= '0;
              state_q  <= ST_IDLE;
            end else begin
              bus_out <= byte_q[slot_q[$clog2(DATA_BITS)-1:0]];
              slot_q  <= slot_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/echo_bus_tx_chk.sv
module echo_bus_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic bus_out,
  input logic bus_s,
  input logic sent_p,
  input logic clash_p,
  input logic abort_p
);
  // R6: completion pulse lasts one cycle
  a_r6_sent_single: assert property (@(posedge clk) disable iff (rst)
    sent_p |=> !sent_p);

  // R7: on a collision the line is already released
  a_r7_clash_released: assert property (@(posedge clk) disable iff (rst)
    clash_p |-> (bus_out && in_ready));

  // R4: an aborted attempt never drives the line
  a_r4_abort_no_drive: assert property (@(posedge clk) disable iff (rst)
    abort_p |-> (bus_out && in_ready));

  // R2: ready only drops after a byte was offered
  a_r2_ready_falls_on_take: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> $past(in_valid));

  // R3: a start edge follows two high synchronized samples
  a_r3_launch_after_idle: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_out) && !$past(rst)) |-> ($past(bus_s) && $past(bus_s, 2)));

  // R2: end-of-attempt pulses are mutually exclusive
  a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sent_p, clash_p, abort_p}));
endmodule

bind echo_bus_tx echo_bus_tx_chk u_chk (
  .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
  .bus_out (bus_out), .bus_s (bus_s), .sent_p (sent_p),
  .clash_p (clash_p), .abort_p (abort_p)
);

// File: tb/echo_bus_tx_tb_top.sv
`timescale 1ns/1ps
module echo_bus_tx_tb_top;
  localparam int B = 16;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic in_ready, bus_out, sent_p, clash_p, abort_p;
  logic pull_low = 1'b0;
  logic bus_line;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  assign bus_line = bus_out & ~pull_low;

  echo_bus_tx #(.BIT_CLKS(B)) dut_i (
    .clk (clk), .rst (rst), .in_data (in_data), .in_valid (in_valid),
    .in_ready (in_ready), .bus_out (bus_out), .bus_in (bus_line),
    .sent_p (sent_p), .clash_p (clash_p), .abort_p (abort_p)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s @cyc %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // hit: data bit index where another station pulls low (-1: none)
  task automatic send_byte(input logic [7:0] d, input int hit,
                           input bit exp_clash, input bit hold);
    int e0, f;
    @(negedge clk);
    in_data = d;
    in_valid = 1'b1;
    chk("R2 ready before take", in_ready, 1);
    @(negedge clk);
    e0 = cyc;
    chk("R2 ready low after take", in_ready, 0);
    if (hold) in_data = ~d; else in_valid = 1'b0;
    wait_cyc(e0 + 1);
    chk("R3 line high during check", bus_out, 1);
    wait_cyc(e0 + 2);
    chk("R3 start edge two cycles after take", bus_out, 0);
    f = e0 + 2;
    for (int k = 0; k < 10; k++) begin
      int ev;
      if (exp_clash && k == 9) break;
      ev = (k == 0) ? 0 : (k == 9) ? 1 : int'(d[k-1]);
      wait_cyc(f + k*B);
      chk($sformatf("R5 bit %0d first cycle", k), bus_out, ev);
      if (hit >= 0 && k == hit + 1) begin
        wait_cyc(f + k*B + 2);
        pull_low = 1'b1;
        wait_cyc(f + k*B + B - 3);
        pull_low = 1'b0;
      end
      wait_cyc(f + k*B + B - 1);
      chk($sformatf("R5 bit %0d last cycle", k), bus_out, ev);
      chk("R7 no clash mid-frame", clash_p, 0);
      if (k == 5) chk("R2 ready low while busy", in_ready, 0);
    end
    if (hold) begin
      in_valid = 1'b0;
      chk("R9 busy input ignored", 1, 1);
    end
    if (exp_clash) begin
      wait_cyc(f + 9*B);
      chk("R7 clash pulse", clash_p, 1);
      chk("R7 line released on clash", bus_out, 1);
      chk("R7 ready on clash", in_ready, 1);
      wait_cyc(f + 10*B + 2);
      chk("R7 no done after clash", sent_p, 0);
    end else begin
      wait_cyc(f + 10*B);
      chk("R6 done pulse", sent_p, 1);
      chk("R6 ready with done", in_ready, 1);
      chk("R8 no clash", clash_p, 0);
      wait_cyc(f + 10*B + 1);
      chk("R6 done one cycle", sent_p, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 line high", bus_out, 1);
    chk("R1 ready high", in_ready, 1);
    chk("R1 pulses low", {sent_p, clash_p, abort_p}, 0);
  endtask

  task automatic t_abort;
    int e0;
    @(negedge clk);
    pull_low = 1'b1;
    repeat (4) @(negedge clk);
    in_data = 8'h5A;
    in_valid = 1'b1;
    @(negedge clk);
    e0 = cyc;
    in_valid = 1'b0;
    chk("R4 line held high", bus_out, 1);
    wait_cyc(e0 + 1);
    chk("R4 abort pulse", abort_p, 1);
    chk("R4 ready back", in_ready, 1);
    chk("R4 not driven", bus_out, 1);
    wait_cyc(e0 + 2);
    chk("R4 abort one cycle", abort_p, 0);
    pull_low = 1'b0;
    repeat (3*B) begin
      @(negedge clk);
      if (bus_out !== 1'b1) chk("R4 stays idle after abort", bus_out, 1);
    end
    chk("R4 idle after abort", bus_out, 1);
  endtask

  task automatic t_quiet_after;
    int t0;
    t0 = cyc;
    wait_cyc(t0 + 3*B);
    chk("R9 no new frame without valid", bus_out, 1);
    chk("R9 ready idle", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    send_byte(8'hA5, -1, 1'b0, 1'b0);
    send_byte(8'h3C, -1, 1'b0, 1'b0);
    send_byte(8'h01, -1, 1'b0, 1'b0);
    send_byte(8'h80, -1, 1'b0, 1'b0);
    send_byte(8'hFF, 3, 1'b1, 1'b0);
    send_byte(8'h00, 4, 1'b0, 1'b0);
    t_abort();
    send_byte(8'h0F, -1, 1'b0, 1'b1);
    t_quiet_after();
    send_byte(8'hF7, 7, 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule